// File: doc/BRIEF.md
# Undersampling PLL Self-Test Measurement Controller

This controller grades a PLL on chip from two sampled bit streams. A sampling clock runs slightly slower than a whole multiple of the reference period. Each sample therefore lands a little later in the waveform than the one before. The time step per sample equals the difference between the sampling period and the nearest multiple of the reference period, and the PLL output frequency does not change it. For example, a 10 ns reference sampled every 10.001 ns gives a step of 1 ps. The block receives one sampled reference bit and six sampled PLL output bits, and it measures one selected output. Every result is a count of sampling-clock steps.

After a start pulse the controller first waits for lock. Next it measures over a programmable number of beat periods. A beat period is the interval between two rising transitions of the sampled reference bit. The controller then compares each result with a lower limit and an upper limit that were shifted in serially. A serial read port returns the raw results, one pass bit for each measurement, an overall fail bit and a timeout bit. Both serial ports work like the data registers behind a test access port. The TAP state machine itself is outside the block.

Top module: `bist_pll_undersample_ctrl`

## Requirements
- R1: A start pulse restarts the controller from any state. In the cycle after start, `done` is low, and all results and status bits are cleared.
- R2: A beat begins at each sample where `samp_ref` is 1 and was 0 one sample earlier. That rising sample is position 0 of the new beat. Beats are counted only from the first rising sample seen after start.
- R3: Duty is the number of samples of the selected output that read 1 within the last measured beat. The count includes position 0 of that beat.
- R4: Jitter is the largest minus the smallest position of the first output rising transition in each measured beat, taken over `cfg_beats` beats. A beat with no such transition does not count toward jitter. Jitter is 0 if no measured beat had such a transition.
- R5: Phase is the position of the first output rising transition in the first measured beat. It is 16'hFFFF if that beat has no such transition.
- R6: Ratio is the number of rising transitions of the selected output within the last measured beat.
- R7: Lock time is the number of samples counted from the start sample to the end of the LOCK_BEATS-th consecutive complete beat whose ratio lies within the ratio limits. Measurement beats begin at that same sample.
- R8: Suppose lock is not reached before the sample count reaches LOCK_TMO. Then `done` rises at that sample, the timeout bit and the fail bit are set, and all pass bits are 0.
- R9: The limit register is 160 bits long and is shifted in LSB first on `lim_si` while `lim_shift` is high. Measurement m uses bits [32m+15:32m] as its lower limit and bits [32m+31:32m+16] as its upper limit, with m = 0 duty, 1 jitter, 2 phase, 3 ratio, 4 lock time.
- R10: Pass bit m is 1 exactly when lower(m) <= result(m) <= upper(m). The fail bit is 1 when any pass bit is 0.
- R11: `done` rises in the sample that closes beat number `cfg_beats` of the measurement. A `cfg_beats` value of 0 acts as 1. After that, `done` and all results stay frozen until the next start.
- R12: `out_sel` (0 to 5) picks which output is measured. Activity on the other outputs has no effect on any result.
- R13: `rd_capture` copies the 87-bit status word into the read register. `rd_shift` shifts that register out LSB first on `rd_so`. The word holds result m at bits [16m+15:16m], pass m at bit 80+m, fail at bit 85 and timeout at bit 86.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start pulse; clears the controller and begins a run |
| out_sel | input | 3 | Index of the PLL output to measure |
| cfg_beats | input | 11 | Number of measured beats (0 acts as 1) |
| samp_ref | input | 1 | Sampled reference clock bit |
| samp_out | input | 6 | Sampled PLL output bits |
| lim_shift | input | 1 | Shift enable for the limit register |
| lim_si | input | 1 | Serial limit data, LSB first |
| rd_capture | input | 1 | Load the status word into the read register |
| rd_shift | input | 1 | Shift enable for the read register |
| rd_so | output | 1 | Serial read data, LSB first |
| done | output | 1 | Run complete; results are frozen |

## Verification
The stimulus is built from pulse trains that repeat once per beat, with the output pulse position moved randomly from beat to beat. Steady pulses with no movement show that jitter drops to zero when the position does not change. Moved pulses separate the first-beat phase from the min/max spread. A second pulse placed inside each beat shows that ratio counts transitions rather than high samples. Random noise on the unselected outputs makes any wrong selection visible. Limits are drawn as wide, exact-match or just-above-the-result, so each pass bit is seen both set and clear. A flat output that never meets the ratio floor drives the timeout path. A one-beat window probes the point where phase, duty and completion all fall in the same beat.

// File: rtl/bist_pkg.sv
package bist_pkg;

    localparam int BIST_MW = 16;
    localparam int NMEAS   = 5;

    localparam int M_DUTY  = 0;
    localparam int M_JIT   = 1;
    localparam int M_PHASE = 2;
    localparam int M_RATIO = 3;
    localparam int M_LOCK  = 4;

    typedef logic [BIST_MW-1:0] word_t;

    typedef struct packed {
        word_t len;
        word_t high;
        word_t rises;
        word_t rpos;
        logic  rvalid;
    } beat_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LOCK,
        ST_MEAS,
        ST_DONE
    } ctl_st_e;

    function automatic word_t sat_inc(word_t a, logic b);
        return (b && (a != '1)) ? word_t'(a + 1'b1) : a;
    endfunction

endpackage

// File: rtl/bist_beat_tracker.sv
module bist_beat_tracker
    import bist_pkg::*;
#(
    parameter int NOUT = 6,
    localparam int SELW = $clog2(NOUT)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [SELW-1:0] sel,
    input  logic            samp_ref,
    input  logic [NOUT-1:0] samp_out,
    output logic            ref_rise,
    output beat_t           cur
);

    typedef struct packed {
        beat_t b;
        logic  ref_prev;
        logic  out_prev;
    } trk_t;

    trk_t q, d;
    logic obit, orise;

    always_comb begin
        obit     = (int'(sel) < NOUT) ? samp_out[sel] : 1'b0;
        orise    = obit & ~q.out_prev;
        ref_rise = samp_ref & ~q.ref_prev;
        d          = q;
        d.ref_prev = samp_ref;
        d.out_prev = obit;
        if (ref_rise) begin
            d.b.len    = word_t'(1);
            d.b.high   = word_t'(obit);
            d.b.rises  = word_t'(orise);
            d.b.rpos   = '0;
            d.b.rvalid = orise;
        end else begin
            d.b.len   = sat_inc(q.b.len, 1'b1);
            d.b.high  = sat_inc(q.b.high, obit);
            d.b.rises = sat_inc(q.b.rises, orise);
            if (orise && !q.b.rvalid) begin
                d.b.rpos   = q.b.len;
                d.b.rvalid = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign cur = q.b;

    // R2: a beat in progress never holds more high samples than samples
    a_r2_high_within_len: assert property (@(posedge clk) disable iff (!rst_n)
        $past(ref_rise) |-> (cur.high <= cur.len));

endmodule

// File: rtl/bist_limit_chain.sv
module bist_limit_chain
    import bist_pkg::*;
#(
    parameter int N  = NMEAS,
    parameter int MW = BIST_MW,
    localparam int W = 2 * N * MW
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  shift_en,
    input  logic                  si,
    output logic [N-1:0][MW-1:0]  lim_lo,
    output logic [N-1:0][MW-1:0]  lim_hi
);

    logic [W-1:0] chain_q, chain_d;

    always_comb begin
        chain_d = chain_q;
        if (shift_en) chain_d = {si, chain_q[W-1:1]};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    for (genvar m = 0; m < N; m++) begin : g_field
        assign lim_lo[m] = chain_q[2*m*MW      +: MW];
        assign lim_hi[m] = chain_q[2*m*MW + MW +: MW];
    end

    // R9: limits hold whenever no shift is requested
    a_r9_limits_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !shift_en |=> $stable(lim_lo) && $stable(lim_hi));

endmodule

// File: rtl/bist_result_port.sv
module bist_result_port #(
    parameter int W = 87
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         capture,
    input  logic         shift_en,
    input  logic [W-1:0] pdata,
    output logic         so
);

    logic [W-1:0] sr_q, sr_d;

    always_comb begin
        sr_d = sr_q;
        if (capture)       sr_d = pdata;
        else if (shift_en) sr_d = {1'b0, sr_q[W-1:1]};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sr_q <= '0;
        else        sr_q <= sr_d;
    end

    assign so = sr_q[0];

    // R13: a capture presents bit 0 of the status word on the serial output
    a_r13_capture_bit0: assert property (@(posedge clk) disable iff (!rst_n)
        capture |=> (so == $past(pdata[0])));

endmodule

// File: rtl/bist_pll_undersample_ctrl.sv
module bist_pll_undersample_ctrl
    import bist_pkg::*;
#(
    parameter int NOUT       = 6,
    parameter int BEATW      = 11,
    parameter int LOCK_BEATS = 4,
    parameter int LOCK_TMO   = 1000,
    localparam int SELW = $clog2(NOUT),
    localparam int CW   = $clog2(LOCK_BEATS + 1),
    localparam int RW   = NMEAS * BIST_MW + NMEAS + 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [SELW-1:0]  out_sel,
    input  logic [BEATW-1:0] cfg_beats,
    input  logic             samp_ref,
    input  logic [NOUT-1:0]  samp_out,
    input  logic             lim_shift,
    input  logic             lim_si,
    input  logic             rd_capture,
    input  logic             rd_shift,
    output logic             rd_so,
    output logic             done
);

    typedef struct packed {
        ctl_st_e                  st;
        logic                     synced;
        word_t                    cyc;
        logic [CW-1:0]            cons;
        logic [BEATW-1:0]         nb;
        word_t                    rmin;
        word_t                    rmax;
        logic                     rany;
        logic [NMEAS-1:0][BIST_MW-1:0] res;
        logic [NMEAS-1:0]         pass;
        logic                     fail;
        logic                     tmo;
        logic                     done;
    } ctl_t;

    ctl_t  q, d;
    beat_t cur;
    logic  ref_rise;
    logic [NMEAS-1:0][BIST_MW-1:0] lim_lo, lim_hi;

    bist_beat_tracker #(.NOUT(NOUT)) u_trk (
        .clk      (clk),
        .rst_n    (rst_n),
        .sel      (out_sel),
        .samp_ref (samp_ref),
        .samp_out (samp_out),
        .ref_rise (ref_rise),
        .cur      (cur)
    );

    bist_limit_chain #(.N(NMEAS), .MW(BIST_MW)) u_lim (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (lim_shift),
        .si       (lim_si),
        .lim_lo   (lim_lo),
        .lim_hi   (lim_hi)
    );

    logic [BEATW-1:0]              nb_n, beats_eff;
    logic [NMEAS-1:0][BIST_MW-1:0] fin;
    logic [NMEAS-1:0]              pass_n;
    word_t                         rmin_n, rmax_n;
    logic                          rany_n, in_ratio;

    always_comb begin
        d         = q;
        nb_n      = q.nb + 1'b1;
        beats_eff = (cfg_beats == '0) ? BEATW'(1) : cfg_beats;
        fin       = q.res;
        pass_n    = '0;
        rmin_n    = q.rmin;
        rmax_n    = q.rmax;
        rany_n    = q.rany;
        in_ratio  = (cur.rises >= lim_lo[M_RATIO]) && (cur.rises <= lim_hi[M_RATIO]);

        unique case (q.st)
            ST_LOCK: begin
                d.cyc = q.cyc + 1'b1;
                if (ref_rise) begin
                    if (!q.synced) begin
                        d.synced = 1'b1;
                    end else if (in_ratio) begin
                        d.cons = q.cons + 1'b1;
                        if (int'(q.cons) + 1 == LOCK_BEATS) begin
                            d.res[M_LOCK] = q.cyc + 1'b1;
                            d.st          = ST_MEAS;
                            d.nb          = '0;
                        end
                    end else begin
                        d.cons = '0;
                    end
                end
                if ((d.st == ST_LOCK) && (int'(q.cyc) + 1 >= LOCK_TMO)) begin
                    d.tmo  = 1'b1;
                    d.fail = 1'b1;
                    d.done = 1'b1;
                    d.st   = ST_DONE;
                end
            end
            ST_MEAS: begin
                if (ref_rise) begin
                    if (cur.rvalid) begin
                        rany_n = 1'b1;
                        if (cur.rpos < q.rmin) rmin_n = cur.rpos;
                        if (cur.rpos > q.rmax) rmax_n = cur.rpos;
                    end
                    if (q.nb == '0) fin[M_PHASE] = cur.rvalid ? cur.rpos : '1;
                    d.rmin = rmin_n;
                    d.rmax = rmax_n;
                    d.rany = rany_n;
                    d.nb   = nb_n;
                    if (nb_n == beats_eff) begin
                        fin[M_DUTY]  = cur.high;
                        fin[M_RATIO] = cur.rises;
                        fin[M_JIT]   = rany_n ? word_t'(rmax_n - rmin_n) : '0;
                        for (int m = 0; m < NMEAS; m++) begin
                            pass_n[m] = (fin[m] >= lim_lo[m]) && (fin[m] <= lim_hi[m]);
                        end
                        d.pass = pass_n;
                        d.fail = ~&pass_n;
                        d.done = 1'b1;
                        d.st   = ST_DONE;
                    end
                    d.res = fin;
                end
            end
            default: ;
        endcase

        if (start) begin
            d      = '0;
            d.st   = ST_LOCK;
            d.rmin = '1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    bist_result_port #(.W(RW)) u_rd (
        .clk      (clk),
        .rst_n    (rst_n),
        .capture  (rd_capture),
        .shift_en (rd_shift),
        .pdata    ({q.tmo, q.fail, q.pass, q.res}),
        .so       (rd_so)
    );

    assign done = q.done;

    // R1: start clears completion and status
    a_r1_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> !done && !q.fail && !q.tmo && (q.pass == '0));

    // R8: a timeout always reports failure with no passing measurement
    a_r8_timeout_fails: assert property (@(posedge clk) disable iff (!rst_n)
        q.tmo |-> q.fail && (q.pass == '0) && done);

    // R11: a finished run stays frozen until the next start
    a_r11_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> done && $stable(q.res) && $stable(q.pass) && $stable(q.fail));

    // R4: the jitter window keeps its bounds ordered
    a_r4_bounds_ordered: assert property (@(posedge clk) disable iff (!rst_n)
        q.rany |-> (q.rmax >= q.rmin));

    // R7: a lock reached without timeout lies inside the timeout window
    a_r7_lock_in_window: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !q.tmo) |-> (int'(q.res[M_LOCK]) < LOCK_TMO));

endmodule

// File: tb/tb_bist_pll_undersample_ctrl.sv
`timescale 1ns/1ps
module tb_bist_pll_undersample_ctrl;

    localparam int NS    = 4096;
    localparam int LOCKB = 4;
    localparam int TMO   = 1000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [2:0]  out_sel = '0;
    logic [10:0] cfg_beats = 11'd1;
    logic        samp_ref = 1'b0;
    logic [5:0]  samp_out = '0;
    logic        lim_shift = 1'b0, lim_si = 1'b0;
    logic        rd_capture = 1'b0, rd_shift = 1'b0;
    logic        rd_so, done;

    always #2.5 clk = ~clk;

    bist_pll_undersample_ctrl dut (
        .clk(clk), .rst_n(rst_n), .start(start), .out_sel(out_sel),
        .cfg_beats(cfg_beats), .samp_ref(samp_ref), .samp_out(samp_out),
        .lim_shift(lim_shift), .lim_si(lim_si), .rd_capture(rd_capture),
        .rd_shift(rd_shift), .rd_so(rd_so), .done(done)
    );

    int n_chk = 0, n_bad = 0;
    int cyc_total = 0;
    always @(posedge clk) cyc_total <= cyc_total + 1;

    logic       ref_a [NS];
    logic [5:0] out_a [NS];
    int         n_smp;
    logic [15:0] lo [5], hi [5], er [5];
    logic [4:0]  e_pass;
    logic        e_fail, e_tmo;
    int          e_idx;

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    // Pulse-train builder: one reference rise per beat, output pulse at jittered position
    task automatic build(input int p, input int nbeats, input int jit, input int h,
                         input int pulses, input bit flat, input int lead);
        n_smp = 0;
        for (int i = 0; i < lead; i++) begin
            ref_a[n_smp] = 1'b0; out_a[n_smp] = 6'($urandom); n_smp++;
        end
        for (int b = 0; b < nbeats; b++) begin
            int rb = 1 + ((jit > 0) ? int'($urandom % (jit + 1)) : 0);
            for (int k = 0; k < p; k++) begin
                logic o;
                o = (k >= rb && k < rb + h) || (pulses == 2 && k == rb + h + 1);
                if (flat) o = 1'b0;
                ref_a[n_smp] = (k < p / 2);
                out_a[n_smp] = 6'($urandom);
                out_a[n_smp][out_sel] = o;
                n_smp++;
            end
        end
        out_a[0][out_sel] = 1'b0;
        ref_a[0] = 1'b0;
    endtask

    // Expected values from the requirement definitions R2-R8, R10, R11
    task automatic model();
        int st = 1, cons = 0, nb = 0, eff;
        bit synced = 0, rany = 0, rv = 0;
        logic [15:0] len = 0, high = 0, rises = 0, rpos = 0, mn = 16'hFFFF, mx = 0;
        eff = (cfg_beats == 0) ? 1 : int'(cfg_beats);
        for (int m = 0; m < 5; m++) er[m] = 0;
        e_tmo = 0; e_idx = -1;
        for (int i = 1; i < n_smp; i++) begin
            bit rr, o, orr;
            rr  = ref_a[i] && !ref_a[i-1];
            o   = out_a[i][out_sel];
            orr = o && !out_a[i-1][out_sel];
            if (st == 1) begin
                if (rr) begin
                    if (!synced) synced = 1;
                    else if (rises >= lo[3] && rises <= hi[3]) begin
                        cons++;
                        if (cons == LOCKB) begin er[4] = 16'(i); st = 2; nb = 0; end
                    end else cons = 0;
                end
                if (st == 1 && i >= TMO) begin e_tmo = 1; e_idx = i; break; end
            end else if (rr) begin
                if (rv) begin
                    rany = 1;
                    if (rpos < mn) mn = rpos;
                    if (rpos > mx) mx = rpos;
                end
                if (nb == 0) er[2] = rv ? rpos : 16'hFFFF;
                nb++;
                if (nb == eff) begin
                    er[0] = high; er[3] = rises; er[1] = rany ? 16'(mx - mn) : 16'h0;
                    e_idx = i; break;
                end
            end
            if (rr) begin
                len = 1; high = 16'(o); rises = 16'(orr); rpos = 0; rv = orr;
            end else begin
                if (orr && !rv) begin rpos = len; rv = 1; end
                len++; high += 16'(o); rises += 16'(orr);
            end
        end
    endtask

    task automatic pick_limits(input bit rnd);
        for (int m = 0; m < 5; m++) begin
            if (m == 3) continue;
            lo[m] = 16'h0; hi[m] = 16'hFFFF;
            if (rnd) begin
                int mode = int'($urandom % 3);
                if (mode == 1) begin lo[m] = er[m]; hi[m] = er[m]; end
                if (mode == 2 && er[m] != 16'hFFFF) lo[m] = er[m] + 1;
            end
        end
        for (int m = 0; m < 5; m++) e_pass[m] = !e_tmo && er[m] >= lo[m] && er[m] <= hi[m];
        e_fail = e_tmo || (e_pass != 5'h1F);
    endtask

    task automatic load_limits();
        logic [159:0] v;
        for (int m = 0; m < 5; m++) begin
            v[32*m +: 16] = lo[m]; v[32*m+16 +: 16] = hi[m];
        end
        for (int j = 0; j < 160; j++) begin
            @(negedge clk); lim_shift = 1'b1; lim_si = v[j];
        end
        @(negedge clk); lim_shift = 1'b0;
    endtask

    task automatic run(input string name);
        int k;
        logic [86:0] w;
        load_limits();
        @(negedge clk); start = 1'b1; samp_ref = ref_a[0]; samp_out = out_a[0];
        k = 0;
        @(negedge clk); start = 1'b0;
        chk({name, " R1 done cleared after start"}, 32'(done), 32'd0);
        while (!done && k < 6000) begin
            k++;
            samp_ref = ref_a[(k < n_smp) ? k : n_smp - 1];
            samp_out = out_a[(k < n_smp) ? k : n_smp - 1];
            @(negedge clk);
        end
        chk({name, " R11 done sample index"}, 32'(k), 32'(e_idx));
        repeat (3) @(negedge clk);
        chk({name, " R11 done held"}, 32'(done), 32'd1);
        rd_capture = 1'b1; @(negedge clk); rd_capture = 1'b0; rd_shift = 1'b1;
        for (int j = 0; j < 87; j++) begin w[j] = rd_so; @(negedge clk); end
        rd_shift = 1'b0;
        chk({name, " R3 duty"},  32'(w[15:0]),  32'(er[0]));
        chk({name, " R4 jitter"}, 32'(w[31:16]), 32'(er[1]));
        chk({name, " R5 phase"}, 32'(w[47:32]), 32'(er[2]));
        chk({name, " R6 ratio"}, 32'(w[63:48]), 32'(er[3]));
        chk({name, " R7 lock time"}, 32'(w[79:64]), 32'(er[4]));
        chk({name, " R10 pass bits"}, 32'(w[84:80]), 32'(e_pass));
        chk({name, " R10 fail bit"}, 32'(w[85]), 32'(e_fail));
        chk({name, " R8 timeout bit"}, 32'(w[86]), 32'(e_tmo));
    endtask

    task automatic scenario(input string name, input int p, input int beats, input int jit,
                            input int h, input int pulses, input bit flat, input bit rnd);
        build(p, LOCKB + int'(beats) + 4, jit, h, pulses, flat, 1 + int'($urandom % 4));
        model();
        pick_limits(rnd);
        run(name);
    endtask

    initial begin
        void'($urandom(32'd1234));
        for (int m = 0; m < 5; m++) begin lo[m] = 0; hi[m] = 16'hFFFF; end
        repeat (3) @(negedge clk);
        chk("R1 reset done low", 32'(done), 32'd0);
        rst_n = 1'b1;
        // R3 R4 R5: steady pulse, zero jitter
        out_sel = 3'd0; cfg_beats = 11'd8;
        scenario("steady", 20, 8, 0, 6, 1, 1'b0, 1'b0);
        // R6: two transitions per beat
        out_sel = 3'd2; cfg_beats = 11'd5;
        scenario("double", 24, 5, 6, 3, 2, 1'b0, 1'b0);
        // R11: single-beat window with cfg 0
        out_sel = 3'd5; cfg_beats = 11'd0;
        scenario("onebeat", 16, 1, 4, 2, 1, 1'b0, 1'b1);
        // R12 and random limits
        for (int t = 0; t < 6; t++) begin
            int p;
            p = 12 + int'($urandom % 28);
            out_sel = 3'($urandom % 6);
            cfg_beats = 11'(1 + $urandom % 24);
            scenario("random R12", p, int'(cfg_beats), int'($urandom % (p - 7)), 4,
                     1 + int'($urandom % 2), 1'b0, 1'b1);
        end
        // R8: flat output never meets the ratio floor
        out_sel = 3'd1; cfg_beats = 11'd4; lo[3] = 16'd1; hi[3] = 16'hFFFF;
        scenario("timeout", 20, 56, 0, 2, 1, 1'b1, 1'b0);
        lo[3] = 0;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        wait (cyc_total > 150000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: got hung run expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule